// File: doc/BRIEF.md
# Timed Transition Delay Line

This block repeats every change of a level input at its output a fixed time later. The information sits in the transitions, not in pulses. A rising edge and a falling edge are both events, and both are delayed the same way. In its default setting a 25 MHz clock is counted down to a 100 Hz sample strobe. A 400-stage shift register then holds four seconds of samples at 10 ms resolution. The delayed level also drives one seven-segment digit, which shows 0 or 1.

The input is asynchronous, for example a push button. It passes through a two-flip-flop synchroniser. Each strobe then shifts the synchronised level into the delay storage, and the oldest stage is the delayed output. Every flip-flop runs on the one clock, and the slow rate exists only as a one-cycle enable. The input is a plain level and the output is a plain level, so neither side has a handshake or back-pressure. A level that is held for less than one sample period may not be captured.

Top module: `nrz_delay_line`

## Requirements
- R1: Synchronous active-high reset clears the synchroniser, the prescaler and every delay stage to 0. In the first cycle after reset `delayed_o` is 0 and `seg_n_o` is 7'b1000000.
- R2: A rising input edge that follows the previous edge by at least 2·CLKS_PER_TICK cycles appears as a rising edge of `delayed_o`. Count the input change as seen at clock edge e0+1. The output edge then comes at clock edge e0+D, with (STAGES−1)·CLKS_PER_TICK+3 ≤ D ≤ STAGES·CLKS_PER_TICK+2.
- R3: A falling input edge, spaced as in R2, appears as a falling edge of `delayed_o` within the same window.
- R4: `delayed_o` never changes unless a matching input change came earlier. The number of output transitions equals the number of input transitions.
- R5: A train of transitions spaced at least 2·CLKS_PER_TICK apart is reproduced in order, with the same alternation of levels.
- R6: `seg_n_o` is active low, with bit order {g,f,e,d,c,b,a}. It shows 0 (7'b1000000) when `delayed_o` is 0 and 1 (7'b1111001) when `delayed_o` is 1.
- R7: The sample strobe recurs exactly every CLKS_PER_TICK clocks from reset. `delayed_o` changes only on clock edges where the strobe is high, so any two output changes lie a multiple of CLKS_PER_TICK apart.
- R8: The input passes through two synchroniser flip-flops before it is sampled. An input change therefore never reaches the output sooner than (STAGES−1)·CLKS_PER_TICK+3 clock edges.
- R9: CLKS_PER_TICK and STAGES are parameters (defaults 250000 and 400). Every counter width and storage length is derived from them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 1 | Asynchronous level input to be delayed |
| delayed_o | output | 1 | Input level, delayed by STAGES sample periods |
| seg_n_o | output | 7 | Active-low segments {g,f,e,d,c,b,a} showing the delayed level as 0 or 1 |

## Verification
The bench builds the block with 4 clocks per tick and 8 stages. It sweeps single pulses of both polarities over every phase of the input change relative to the strobe and over a range of pulse widths. This shows whether the delay window holds at both of its ends, and for rising and falling edges alike. A dense train of toggles separates order and alternation faults from plain latency faults. A reset taken while the input is held high shows whether storage is cleared, and whether the held level then travels through as a fresh event. Checking the spacing of output changes modulo the tick period exposes a strobe that runs at the wrong rate.

// File: rtl/nrzd_pkg.sv
package nrzd_pkg;

  // Active-low segment pattern, bit order {g,f,e,d,c,b,a}
  typedef logic [6:0] seg_t;

  function automatic seg_t hex_to_seg_n(input logic [3:0] nib);
    seg_t on;
    case (nib)
      4'h0: on = 7'b0111111;
      4'h1: on = 7'b0000110;
      4'h2: on = 7'b1011011;
      4'h3: on = 7'b1001111;
      4'h4: on = 7'b1100110;
      4'h5: on = 7'b1101101;
      4'h6: on = 7'b1111101;
      4'h7: on = 7'b0000111;
      4'h8: on = 7'b1111111;
      4'h9: on = 7'b1101111;
      4'hA: on = 7'b1110111;
      4'hB: on = 7'b1111100;
      4'hC: on = 7'b0111001;
      4'hD: on = 7'b1011110;
      4'hE: on = 7'b1111001;
      default: on = 7'b1110001;
    endcase
    return ~on;
  endfunction

endpackage

// File: rtl/nrzd_sync.sv
module nrzd_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [DEPTH-1:0] flop_q;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst) flop_q[g] <= 1'b0;
        else if (g == 0) flop_q[g] <= async_i;
        else flop_q[g] <= flop_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_o = flop_q[DEPTH-1];
endmodule

// File: rtl/nrzd_prescaler.sv
module nrzd_prescaler #(
  parameter int PERIOD = 250000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  generate
    if (PERIOD == 1) begin : g_every
      assign tick_o = ~rst;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/nrzd_delay_store.sv
module nrzd_delay_store #(
  parameter int STAGES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic din,
  output logic head_o,
  output logic tail_o
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else if (shift_en) stage_q[0] <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else if (shift_en) stage_q <= {stage_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign head_o = stage_q[0];
  assign tail_o = stage_q[STAGES-1];
endmodule

// File: rtl/nrzd_seg_decode.sv
module nrzd_seg_decode
  import nrzd_pkg::*;
(
  input  logic [3:0] nibble_i,
  output seg_t       seg_n_o
);
  always_comb seg_n_o = hex_to_seg_n(nibble_i);
endmodule

// File: rtl/nrz_delay_line.sv
module nrz_delay_line #(
  parameter int CLKS_PER_TICK = 250000,
  parameter int STAGES        = 400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_i,
  output logic       delayed_o,
  output logic [6:0] seg_n_o
);
  localparam int SYNC_DEPTH = 2;

  logic tick;
  logic sync_lvl;
  logic head;

  nrzd_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .async_i(btn_i), .sync_o(sync_lvl)
  );

  nrzd_prescaler #(.PERIOD(CLKS_PER_TICK)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  nrzd_delay_store #(.STAGES(STAGES)) u_store (
    .clk(clk), .rst(rst), .shift_en(tick), .din(sync_lvl),
    .head_o(head), .tail_o(delayed_o)
  );

  nrzd_seg_decode u_seg (
    .nibble_i({3'b000, delayed_o}), .seg_n_o(seg_n_o)
  );
endmodule

// File: rtl/nrzd_checker.sv
module nrzd_checker #(
  parameter int N = 250000
) (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       sync_lvl,
  input logic       head,
  input logic       delayed,
  input logic [6:0] seg_n
);
  localparam int GW = $clog2(N + 1) + 1;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || tick) gap_q <= '0;
    else gap_q <= gap_q + 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!delayed && !head)); // R1
  AST_SEG_MATCH: assert property (@(posedge clk) disable iff (rst)
    seg_n == (delayed ? 7'b1111001 : 7'b1000000)); // R6
  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q == GW'(N - 1))); // R7
  AST_TICK_DUE: assert property (@(posedge clk) disable iff (rst)
    (gap_q == GW'(N - 1)) |-> tick); // R7
  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(delayed)); // R7
  AST_SYNC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    tick |=> (head == $past(sync_lvl))); // R8
endmodule

bind nrz_delay_line nrzd_checker #(.N(CLKS_PER_TICK)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .sync_lvl(sync_lvl),
  .head(head), .delayed(delayed_o), .seg_n(seg_n_o)
);

// File: tb/nrz_delay_line_tb.sv
module nrz_delay_line_tb;
  localparam int N = 4;
  localparam int S = 8;
  localparam int DMIN = (S - 1) * N + 3;
  localparam int DMAX = S * N + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic dly;
  logic [6:0] seg;

  int vec = 0;
  int bad = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  logic last_out = 1'b0;
  int in_t[0:63];
  logic in_v[0:63];
  int out_t[0:63];
  logic out_v[0:63];
  int ni = 0;
  int no = 0;

  nrz_delay_line #(.CLKS_PER_TICK(N), .STAGES(S)) u_dut (
    .clk(clk), .rst(rst), .btn_i(btn), .delayed_o(dly), .seg_n_o(seg)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: record output changes, check segment encoding
  always @(negedge clk) begin
    if (!rst && mon_en) begin
      if (dly !== last_out) begin
        if (no < 64) begin
          out_t[no] = cyc;
          out_v[no] = dly;
        end
        no++;
        last_out = dly;
      end
      chk(seg === (dly ? 7'b1111001 : 7'b1000000), "R6 segment pattern",
          int'(seg), dly ? 7'b1111001 : 7'b1000000);
    end
  end

  task automatic toggle();
    @(negedge clk);
    btn = ~btn;
    in_t[ni] = cyc;
    in_v[ni] = btn;
    ni++;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic evaluate();
    chk(no == ni, "R4 transition count", no, ni);
    for (int i = 0; i < ni && i < no; i++) begin
      int d;
      d = out_t[i] - in_t[i];
      chk(out_v[i] === in_v[i], "R5 order and level", int'(out_v[i]), int'(in_v[i]));
      // R9: window uses the overridden parameters
      if (in_v[i]) chk(d >= DMIN && d <= DMAX, "R2 rising delay", d, S * N);
      else chk(d >= DMIN && d <= DMAX, "R3 falling delay", d, S * N);
      chk(d >= DMIN, "R8 minimum latency", d, DMIN);
      if (i > 0) chk((out_t[i] - out_t[0]) % N == 0, "R7 strobe alignment",
                     (out_t[i] - out_t[0]) % N, 0);
    end
    ni = 0;
    no = 0;
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dly === 1'b0, "R1 reset output", int'(dly), 0);
    chk(seg === 7'b1000000, "R1 reset segments", int'(seg), 7'b1000000);
    mon_en = 1'b1;
    idle(3 * S * N);
    chk(no == 0, "R4 no spurious change", no, 0);

    // phase x width sweep of single pulses, both polarities
    for (int ph = 0; ph < N; ph++) begin
      for (int w = 2 * N; w <= 3 * N + 1; w++) begin
        idle(ph);
        toggle();
        idle(w - 1);
        toggle();
        idle(S * N + 3 * N);
        evaluate();
      end
    end

    // dense train
    for (int k = 0; k < 12; k++) begin
      toggle();
      idle(2 * N - 1 + (k % 3));
    end
    idle(S * N + 3 * N);
    evaluate();

    // reset while input held high
    toggle();
    idle(S * N + 3 * N);
    evaluate();
    chk(dly === 1'b1, "R2 held high reached output", int'(dly), 1);
    mon_en = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(dly === 1'b0, "R1 mid-run reset clears", int'(dly), 0);
    in_t[0] = cyc - 1;
    in_v[0] = 1'b1;
    ni = 1;
    no = 0;
    last_out = 1'b0;
    mon_en = 1'b1;
    idle(S * N + 3 * N);
    evaluate();

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    vec++;
    bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule